// File: doc/BRIEF.md
# Serial EEPROM Burst Reader

This block fetches a run of consecutive bytes from a serial EEPROM. It drives the memory's four-wire bus itself: a bus-enable line, an active-low chip select, a serial clock, and the data line toward the memory. It also reads the memory's data line back. A client gives a relative offset, a byte count and a base offset, and pulses `start`. The block gates the bus on and selects the device. It then sends a read command and a 16-bit address, clocks in the requested bytes, and hands out each byte with a one-cycle strobe.

Every bus step lasts `half_div + 1` clock cycles. This sets the serial clock rate without changing the order of events. A request ends by releasing the bus in a fixed order and pulsing `done`. A request that cannot be served is answered with `done` and `error` together, and the bus stays quiet. This happens when the memory is reported missing or when the base offset does not fit in 16 bits.

Top module: `eerd_reader`

## Requirements
- R1: While reset is asserted, `bus_en` is 0, `sel_n` is 1, `sclk` is 0, and `byte_valid` and `done` are 0.
- R2: Arming takes two steps. `bus_en` rises first while `sel_n` stays high, and `sel_n` falls exactly `half_div+1` cycles later.
- R3: Release takes two steps. `sel_n` rises first while `bus_en` stays high, and `bus_en` falls exactly `half_div+1` cycles later. Every accepted request ends with both lines released.
- R4: Each bit sent to the memory is placed on `mosi` before `sclk` rises. `mosi` holds steady for the whole high phase, and `sclk` is high only while the device is selected.
- R5: Each bit from the memory is sampled on `miso` while `sclk` is high, then `sclk` falls. The first sampled bit of a byte is its bit 7.
- R6: The serial frame starts with the command byte 0x03, sent bit 7 first.
- R7: The address follows the command, high byte then low byte, and equals `offset + base` truncated to 16 bits.
- R8: Exactly `count` bytes are delivered in rising address order. Each is marked by a single-cycle `byte_valid` pulse, and a count of 0 delivers none.
- R9: If `present` is 0 or `base` is above 0xFFFF, `done` and `error` pulse together in the cycle after `start`, and `bus_en` never rises.
- R10: Every high phase of `sclk` lasts exactly `half_div+1` clock cycles.
- R11: A `start` pulse that arrives while a request is in progress has no effect on the bus frame, the bytes delivered, or the number of `done` pulses.
- R12: `done` pulses once per request, for one cycle, and only when `bus_en` is 0 and `sel_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only while idle |
| offset | input | 16 | Relative byte offset |
| count | input | 16 | Number of bytes to read |
| base | input | 17 | Base offset; values above 0xFFFF are rejected |
| present | input | 1 | Memory reported present |
| half_div | input | 8 | Bus step length minus one, in clock cycles |
| miso | input | 1 | Serial data from the memory |
| bus_en | output | 1 | Bus ownership enable |
| sel_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the memory |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_data | output | 8 | Received byte |
| done | output | 1 | Request finished |
| error | output | 1 | Request rejected, with `done` |

## Verification
The hardest case to reach from the ports is a second `start` that lands in the middle of a live transfer. To reach it, the bench waits a fixed number of cycles into a slow request and then pulses `start` with a different offset. A bus model in the bench decodes the frame and serves bytes from a computed pattern. The bench confirms that the captured address, the byte stream and the `done` count still match the first request only. The address sum carrying past 0xFFFF and a base of exactly 0xFFFF are also driven, so that address truncation is seen on the wire.

// File: rtl/eerd_pkg.sv
package eerd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ARM_EN,
    ST_ARM_CS,
    ST_TX_SET,
    ST_TX_HI,
    ST_TX_LO,
    ST_RX_HI,
    ST_RX_LO,
    ST_REL
  } eerd_state_e;

  localparam logic [7:0] RD_OPCODE = 8'h03;
endpackage

// File: rtl/eerd_tick.sv
module eerd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == half_div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/eerd_tx_shift.sv
module eerd_tx_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         bit_out,
  output logic         last
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sr_q, sr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign bit_out = sr_q[W-1];
  assign last    = (cnt_q == CW'(W-1));

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (load) begin
      sr_d  = load_val;
      cnt_d = '0;
    end else if (shift) begin
      sr_d  = {sr_q[W-2:0], 1'b0};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/eerd_rx_shift.sv
module eerd_rx_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       sample,
  input  logic       advance,
  input  logic       bit_in,
  output logic [7:0] byte_out,
  output logic       last_bit
);
  logic [7:0] sr_q, sr_d;
  logic [2:0] idx_q, idx_d;

  assign byte_out = sr_q;
  assign last_bit = (idx_q == 3'd7);

  always_comb begin
    sr_d  = sr_q;
    idx_d = idx_q;
    if (clear) begin
      sr_d  = '0;
      idx_d = '0;
    end else begin
      if (sample)  sr_d  = {sr_q[6:0], bit_in};
      if (advance) idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else begin
      sr_q  <= sr_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/eerd_reader.sv
module eerd_reader #(
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] offset,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W:0]   base,
  input  logic              present,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              miso,
  output logic              bus_en,
  output logic              sel_n,
  output logic              sclk,
  output logic              mosi,
  output logic              byte_valid,
  output logic [7:0]        byte_data,
  output logic              done,
  output logic              error
);
  import eerd_pkg::*;

  localparam int FRAME_W = 8 + ADDR_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign srst_n = rst_q[1];

  eerd_state_e      state_q, state_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             valid_q, valid_d;
  logic [7:0]       data_q, data_d;
  logic             done_q, done_d;
  logic             err_q, err_d;

  logic tick, tx_bit, tx_last, rx_last;
  logic [7:0] rx_byte;
  logic idle, can_serve, accept, reject;

  assign idle      = (state_q == ST_IDLE);
  assign can_serve = present && !base[ADDR_W];
  assign accept    = start && idle && can_serve;
  assign reject    = start && idle && !can_serve;

  eerd_tick #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst_n(srst_n), .run(!idle), .half_div(half_div), .tick(tick)
  );

  eerd_tx_shift #(.W(FRAME_W)) tx_i (
    .clk(clk), .rst_n(srst_n), .load(accept),
    .load_val({RD_OPCODE, offset + base[ADDR_W-1:0]}),
    .shift(tick && state_q == ST_TX_LO),
    .bit_out(tx_bit), .last(tx_last)
  );

  eerd_rx_shift rx_i (
    .clk(clk), .rst_n(srst_n), .clear(accept),
    .sample(tick && state_q == ST_RX_HI),
    .advance(tick && state_q == ST_RX_LO),
    .bit_in(miso), .byte_out(rx_byte), .last_bit(rx_last)
  );

  // next state
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    valid_d = 1'b0;
    data_d  = data_q;
    done_d  = reject;
    err_d   = reject;
    case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_ARM_EN;
        rem_d   = count;
      end
      ST_ARM_EN: if (tick) state_d = ST_ARM_CS;
      ST_ARM_CS: if (tick) state_d = ST_TX_SET;
      ST_TX_SET: if (tick) state_d = ST_TX_HI;
      ST_TX_HI:  if (tick) state_d = ST_TX_LO;
      ST_TX_LO:  if (tick) begin
        if (!tx_last)            state_d = ST_TX_SET;
        else if (rem_q == '0)    state_d = ST_REL;
        else                     state_d = ST_RX_HI;
      end
      ST_RX_HI:  if (tick) state_d = ST_RX_LO;
      ST_RX_LO:  if (tick) begin
        if (rx_last) begin
          valid_d = 1'b1;
          data_d  = rx_byte;
          rem_d   = rem_q - 1'b1;
          state_d = (rem_q == CNT_W'(1)) ? ST_REL : ST_RX_HI;
        end else begin
          state_d = ST_RX_HI;
        end
      end
      ST_REL: if (tick) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      valid_q <= valid_d;
      data_q  <= data_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign bus_en     = !idle;
  assign sel_n      = idle || state_q == ST_ARM_EN || state_q == ST_REL;
  assign sclk       = (state_q == ST_TX_HI) || (state_q == ST_RX_HI);
  assign mosi       = (state_q == ST_TX_SET || state_q == ST_TX_HI ||
                       state_q == ST_TX_LO) ? tx_bit : 1'b0;
  assign byte_valid = valid_q;
  assign byte_data  = data_q;
  assign done       = done_q;
  assign error      = err_q;
endmodule

// File: rtl/eerd_reader_chk.sv
module eerd_reader_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] half_div,
  input logic             bus_en,
  input logic             sel_n,
  input logic             sclk,
  input logic             mosi,
  input logic             byte_valid,
  input logic             done,
  input logic             error
);
  logic [DIV_W:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_cnt <= '0;
    else if (sclk) hi_cnt <= hi_cnt + 1'b1;
    else           hi_cnt <= '0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (!bus_en && sel_n && !sclk && !byte_valid && !done));

  assert_arm_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> (bus_en && $past(bus_en)));

  assert_release_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_en) |-> (sel_n && $past(sel_n)));

  assert_clk_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (!sel_n && bus_en));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  assert_reject_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (done && !bus_en));

  assert_half_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_cnt == {1'b0, half_div} + 1'b1));

  assert_done_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_en && sel_n));
endmodule

bind eerd_reader eerd_reader_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .half_div(half_div), .bus_en(bus_en),
  .sel_n(sel_n), .sclk(sclk), .mosi(mosi), .byte_valid(byte_valid),
  .done(done), .error(error)
);

// File: tb/eerd_reader_tb_top.sv
module eerd_reader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] offset = '0;
  logic [15:0] count = '0;
  logic [16:0] base = '0;
  logic        present = 1'b0;
  logic [7:0]  half_div = '0;
  logic        miso;
  logic        bus_en, sel_n, sclk, mosi, byte_valid, done, error;
  logic [7:0]  byte_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  eerd_reader dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .offset(offset), .count(count),
    .base(base), .present(present), .half_div(half_div), .miso(miso),
    .bus_en(bus_en), .sel_n(sel_n), .sclk(sclk), .mosi(mosi),
    .byte_valid(byte_valid), .byte_data(byte_data), .done(done), .error(error)
  );

  function automatic logic [7:0] mem_at(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h96;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model on the serial bus
  int         mbits = 0;
  logic [23:0] mframe = '0;
  logic [15:0] maddr = '0;
  logic [15:0] cap_addr = '0;
  logic [7:0]  cap_cmd = '0;
  logic [7:0]  mbyte = '0;
  logic [2:0]  midx = '0;
  bit          mdata = 0, msampled = 0;
  logic        tx_cap = 1'b0;
  int          tx_unstable = 0;
  int          touched = 0;

  assign miso = mdata ? mbyte[midx] : 1'b0;

  always @(posedge sclk) begin
    if (!sel_n) begin
      if (mbits < 24) begin
        mframe = {mframe[22:0], mosi};
        tx_cap = mosi;
        mbits++;
        if (mbits == 24) begin
          cap_cmd  = mframe[23:16];
          cap_addr = mframe[15:0];
          maddr    = mframe[15:0];
          mbyte    = mem_at(maddr);
          midx     = 3'd7;
          mdata    = 1;
        end
      end else begin
        msampled = 1;
      end
    end
  end

  always @(negedge sclk) begin
    if (mbits <= 24 && !msampled && mosi !== tx_cap) tx_unstable++;
    if (msampled) begin
      msampled = 0;
      if (midx == 3'd0) begin
        maddr = maddr + 16'd1;
        mbyte = mem_at(maddr);
        midx  = 3'd7;
      end else begin
        midx = midx - 3'd1;
      end
    end
  end

  always @(posedge sel_n) begin
    mbits = 0; mdata = 0; msampled = 0;
  end

  always @(posedge bus_en) touched++;

  // scoreboard monitor
  logic [7:0] exp_q[$];
  int  done_cnt = 0;
  bit  last_err = 0;
  int  hi_w = 0, width_bad = 0, cur_div = 0;
  int  gap = 0, arm_gap = -1, rel_gap = -1;
  bit  en_prev = 0, sel_prev = 1, vprev = 0;

  always @(negedge clk) begin
    if (byte_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8", "unexpected byte", byte_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(byte_data == e, "R5 R8", "byte value", byte_data, e);
      end
      if (vprev) chk(0, "R8", "strobe longer than one cycle", 2, 1);
    end
    vprev = byte_valid;
    if (done) begin
      done_cnt++;
      last_err = error;
    end
    if (sclk) hi_w++;
    else if (hi_w != 0) begin
      if (hi_w != cur_div + 1) width_bad++;
      hi_w = 0;
    end
    if (en_prev && sel_prev && !sel_n) arm_gap = gap;
    if (en_prev && !bus_en && sel_prev) rel_gap = gap;
    gap = (bus_en && sel_n) ? gap + 1 : 0;
    en_prev  = bus_en;
    sel_prev = sel_n;
  end

  task automatic run_req(input logic [15:0] off, input logic [15:0] cnt,
                         input logic [16:0] bs, input bit pres,
                         input int dv, input bit late_start);
    int d0, t0;
    bit ok_req;
    logic [15:0] a;
    ok_req = pres && !bs[16];
    a = off + bs[15:0];
    @(negedge clk);
    offset = off; count = cnt; base = bs; present = pres;
    half_div = 8'(dv); cur_div = dv;
    arm_gap = -1; rel_gap = -1; width_bad = 0; tx_unstable = 0;
    cap_cmd = '0; cap_addr = ~a;
    d0 = done_cnt; t0 = touched;
    if (ok_req)
      for (int i = 0; i < cnt; i++) exp_q.push_back(mem_at(a + 16'(i)));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (late_start) begin
      repeat (40) @(negedge clk);
      offset = off + 16'h0100; count = cnt + 16'd3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (done_cnt != d0);
    repeat (6) @(negedge clk);
    chk(done_cnt == d0 + 1, late_start ? "R11 R12" : "R12", "done pulses",
        done_cnt - d0, 1);
    chk(last_err == !ok_req, "R9", "error flag", last_err, !ok_req);
    chk(exp_q.size() == 0, "R8", "bytes missing", exp_q.size(), 0);
    chk(!bus_en && sel_n && !sclk, "R3", "bus released", {bus_en, sel_n, sclk}, 3'b010);
    if (ok_req) begin
      chk(cap_cmd == 8'h03, "R6", "command byte", cap_cmd, 8'h03);
      chk(cap_addr == a, late_start ? "R7 R11" : "R7", "address", cap_addr, a);
      chk(arm_gap == dv + 1, "R2", "arm gap", arm_gap, dv + 1);
      chk(rel_gap == dv + 1, "R3", "release gap", rel_gap, dv + 1);
      chk(width_bad == 0, "R10", "sclk high width errors", width_bad, 0);
      chk(tx_unstable == 0, "R4", "mosi moved while sclk high", tx_unstable, 0);
    end else begin
      chk(touched == t0, "R9", "bus touched on reject", touched - t0, 0);
    end
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_en && sel_n && !sclk && !byte_valid && !done, "R1", "reset outputs",
        {bus_en, sel_n, sclk, byte_valid, done}, 5'b01000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_req(16'h0010, 16'd3, 17'h00100, 1, 0, 0);
    run_req(16'h1234, 16'd2, 17'h00F00, 1, 2, 0);
    run_req(16'hFFF0, 16'd2, 17'h00020, 1, 1, 0);
    run_req(16'h0040, 16'd0, 17'h00000, 1, 1, 0);
    run_req(16'h0040, 16'd2, 17'h00000, 0, 1, 0);
    run_req(16'h0040, 16'd2, 17'h10000, 1, 1, 0);
    run_req(16'h0200, 16'd2, 17'h00000, 1, 1, 1);
    run_req(16'h0001, 16'd1, 17'h0FFFF, 1, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule